// File: doc/BRIEF.md
# Peripheral DMA Request/Acknowledge Handshake Controller

This block serves one DMA channel on the peripheral side of a bus. A peripheral raises a request line. The block brings that line into the clock domain and decides, in level or edge mode, whether a valid request is present. Once the channel is armed, a request starts a run of bus accesses to the peripheral. During each access the block holds an acknowledge strobe high. It waits until the bus ends that access with a transfer-acknowledge or a transfer-error. After the programmed number of successful beats, it pulses a done output.

Software sets up the channel through a small configuration port. A one-cycle arm strobe captures the detection mode, the active polarity, the pacing choice and the beat count. When the channel is idle again it drops its armed flag. A request seen while the channel is unarmed has no effect, so a glitch from pin setup cannot start a transfer. With pacing on, every beat waits for a new valid request, which lets the request line set the pace of memory-to-memory moves.

Top module: `dreq_hs_ctrl`

## Requirements
- R1: The request input passes through a two-flop synchronizer that samples on every rising clock edge. Take an armed channel that is waiting and the edge that first samples a valid request level. The acknowledge goes high after the third rising edge counted from that edge, and not before.
- R2: In level mode (`cfg_level_mode`=1), a request is valid while the synchronized line is high when `cfg_invert`=0, and while it is low when `cfg_invert`=1.
- R3: In edge mode (`cfg_level_mode`=0), only a synchronized 0-to-1 change (`cfg_invert`=0) or a 1-to-0 change (`cfg_invert`=1) makes a request. A line held steady makes none.
- R4: When `cfg_arm` is high while the channel is idle and `cfg_count` is nonzero, the block captures the mode, polarity, pacing and count, raises `armed` and clears `err_flag`. An arm with a zero count, or an arm while the channel is armed, has no effect.
- R5: A request seen while the channel is unarmed starts no access. An edge that happens before arming is not remembered afterwards.
- R6: `ack_out` stays high for the whole of each access until `bus_ta` or `bus_tea` ends it. Outside an access it is low.
- R7: `beat_ok` equals `ack_out` AND `bus_ta` AND NOT `bus_tea`. Only such beats count toward the programmed count, and `bus_tea` wins when both arrive together.
- R8: `done_out` is a one-cycle pulse in the same cycle as the final qualified beat. On the next cycle the channel is idle and `armed` is low.
- R9: A `bus_tea` during an access aborts the transfer. On the next cycle `ack_out` and `armed` are low and `err_flag` is high. `done_out` is never raised for that transfer, and `err_flag` stays high until the next accepted arm.
- R10: With `cfg_pace`=1, each beat after a non-final qualified beat waits for a new valid request. With `cfg_pace`=0, the next access follows at once with `ack_out` held high.
- R11: `bus_ta` and `bus_tea` have no effect while no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_arm | input | 1 | One-cycle strobe that captures the configuration and arms the channel |
| cfg_level_mode | input | 1 | 1 = level-sensitive request, 0 = edge-sensitive request |
| cfg_invert | input | 1 | Selects active-low level or falling edge |
| cfg_pace | input | 1 | 1 = every beat needs a new request |
| cfg_count | input | CNT_W | Number of qualified beats in the transfer |
| req_in | input | 1 | Asynchronous request from the peripheral |
| bus_ta | input | 1 | Transfer-acknowledge: the access completed |
| bus_tea | input | 1 | Transfer-error: the access failed |
| ack_out | output | 1 | Acknowledge strobe, high during each access |
| beat_ok | output | 1 | Qualified beat (acknowledge with transfer-acknowledge) |
| done_out | output | 1 | One-cycle end-of-transfer pulse |
| armed | output | 1 | Channel is armed (waiting or in an access) |
| err_flag | output | 1 | Sticky transfer-error flag |

## Verification
The assertions check on every cycle the rules that link outputs to bus terminations:
- beat qualification;
- done only with a qualified beat, and only for one cycle;
- disarming after done or after an error;
- the acknowledge holding through a pending access;
- no access while unarmed;
- the error flag staying set.

Only the bench's scenarios can show the rules that depend on the request line's history. These are the three-edge synchronizer latency, level versus edge detection with each polarity, the loss of a pre-arm edge, the per-beat wait under pacing, and the exact number of beats against the programmed count. The bench checks them with a reference model compared on every clock.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_WAIT   = 2'd1,
    HS_ACCESS = 2'd2
  } hs_state_t;

  typedef struct packed {
    logic level_mode;
    logic invert;
    logic pace;
  } hs_cfg_t;

endpackage

// File: rtl/dreq_rst_sync.sv
module dreq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dreq_sync_detect.sv
module dreq_sync_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic level_mode,
  input  logic invert,
  output logic req_hit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   rise;
  logic                   fall;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= req_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_in};
      end
    end
  endgenerate

  assign cur = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  always_comb begin
    rise = cur & ~prev_q;
    fall = ~cur & prev_q;
    if (level_mode) req_hit = cur ^ invert;
    else            req_hit = invert ? fall : rise;
  end
endmodule

// File: rtl/dreq_beat_cnt.sv
module dreq_beat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             rem_en;

  always_comb begin
    rem_en = load | dec;
    rem_d  = rem_q;
    if (load)     rem_d = load_val;
    else if (dec) rem_d = rem_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign last = (rem_q == ONE);
endmodule

// File: rtl/dreq_hs_fsm.sv
module dreq_hs_fsm
  import dreq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_arm,
  input  logic             cfg_level_mode,
  input  logic             cfg_invert,
  input  logic             cfg_pace,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             req_hit,
  input  logic             bus_ta,
  input  logic             bus_tea,
  input  logic             cnt_last,
  output logic             ack_out,
  output logic             beat_ok,
  output logic             done_out,
  output logic             armed,
  output logic             err_flag,
  output logic             arm_take,
  output logic             beat_dec,
  output hs_cfg_t          cfg_q
);
  hs_state_t state_q, state_d;
  hs_cfg_t   cfg_d;
  logic      err_q, err_d;
  logic      in_access;
  logic      abort;
  logic      beat;
  logic      finish;

  always_comb begin
    in_access = (state_q == HS_ACCESS);
    arm_take  = (state_q == HS_IDLE) && cfg_arm && (cfg_count != '0);
    abort     = in_access && bus_tea;
    beat      = in_access && bus_ta && !bus_tea;
    finish    = beat && cnt_last;
    beat_dec  = beat && !cnt_last;

    state_d = state_q;
    cfg_d   = cfg_q;
    err_d   = err_q;

    unique case (state_q)
      HS_IDLE: begin
        if (arm_take) begin
          state_d          = HS_WAIT;
          cfg_d.level_mode = cfg_level_mode;
          cfg_d.invert     = cfg_invert;
          cfg_d.pace       = cfg_pace;
          err_d            = 1'b0;
        end
      end
      HS_WAIT: begin
        if (req_hit) state_d = HS_ACCESS;
      end
      HS_ACCESS: begin
        if (abort) begin
          state_d = HS_IDLE;
          err_d   = 1'b1;
        end else if (finish) begin
          state_d = HS_IDLE;
        end else if (beat && cfg_q.pace) begin
          state_d = HS_WAIT;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cfg_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (arm_take) cfg_q <= cfg_d;
      err_q   <= err_d;
    end
  end

  assign ack_out  = in_access;
  assign beat_ok  = beat;
  assign done_out = finish;
  assign armed    = (state_q != HS_IDLE);
  assign err_flag = err_q;
endmodule

// File: rtl/dreq_hs_ctrl.sv
module dreq_hs_ctrl
  import dreq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_arm,
  input  logic             cfg_level_mode,
  input  logic             cfg_invert,
  input  logic             cfg_pace,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             req_in,
  input  logic             bus_ta,
  input  logic             bus_tea,
  output logic             ack_out,
  output logic             beat_ok,
  output logic             done_out,
  output logic             armed,
  output logic             err_flag
);
  logic    rst_n_int;
  logic    req_hit;
  logic    cnt_last;
  logic    arm_take;
  logic    beat_dec;
  hs_cfg_t cfg_q;

  dreq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dreq_sync_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_in     (req_in),
    .level_mode (cfg_q.level_mode),
    .invert     (cfg_q.invert),
    .req_hit    (req_hit)
  );

  dreq_beat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (arm_take),
    .load_val (cfg_count),
    .dec      (beat_dec),
    .last     (cnt_last)
  );

  dreq_hs_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .cfg_arm        (cfg_arm),
    .cfg_level_mode (cfg_level_mode),
    .cfg_invert     (cfg_invert),
    .cfg_pace       (cfg_pace),
    .cfg_count      (cfg_count),
    .req_hit        (req_hit),
    .bus_ta         (bus_ta),
    .bus_tea        (bus_tea),
    .cnt_last       (cnt_last),
    .ack_out        (ack_out),
    .beat_ok        (beat_ok),
    .done_out       (done_out),
    .armed          (armed),
    .err_flag       (err_flag),
    .arm_take       (arm_take),
    .beat_dec       (beat_dec),
    .cfg_q          (cfg_q)
  );
endmodule

// File: rtl/dreq_hs_checker.sv
module dreq_hs_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_arm,
  input logic bus_ta,
  input logic bus_tea,
  input logic ack_out,
  input logic beat_ok,
  input logic done_out,
  input logic armed,
  input logic err_flag
);
  p_no_ack_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !ack_out);

  p_ack_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_out && !bus_ta && !bus_tea) |=> ack_out);

  p_beat_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok |-> (ack_out && bus_ta && !bus_tea));

  p_done_with_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_out |-> beat_ok);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_out |=> (!done_out && !armed));

  p_error_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_out && bus_tea) |=> (!ack_out && !armed && err_flag));

  p_error_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_out && bus_tea) |-> !done_out);

  p_error_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(cfg_arm && !armed)) |=> err_flag);
endmodule

bind dreq_hs_ctrl dreq_hs_checker u_hs_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_arm  (cfg_arm),
  .bus_ta   (bus_ta),
  .bus_tea  (bus_tea),
  .ack_out  (ack_out),
  .beat_ok  (beat_ok),
  .done_out (done_out),
  .armed    (armed),
  .err_flag (err_flag)
);

// File: tb/tb_dreq_hs_ctrl.sv
`timescale 1ns/1ps
module tb_dreq_hs_ctrl;
  localparam int CNT_W    = 8;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_arm = 1'b0, cfg_level_mode = 1'b0, cfg_invert = 1'b0, cfg_pace = 1'b0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic req_in = 1'b0, bus_ta = 1'b0, bus_tea = 1'b0;
  logic ack_out, beat_ok, done_out, armed, err_flag;

  always #10 clk = ~clk;

  dreq_hs_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm), .cfg_level_mode(cfg_level_mode),
    .cfg_invert(cfg_invert), .cfg_pace(cfg_pace), .cfg_count(cfg_count),
    .req_in(req_in), .bus_ta(bus_ta), .bus_tea(bus_tea), .ack_out(ack_out),
    .beat_ok(beat_ok), .done_out(done_out), .armed(armed), .err_flag(err_flag)
  );

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  string scen = "reset";

  // Reference model: 0 idle, 1 waiting for request, 2 access
  int   m_st = 0;
  int   m_rem = 0;
  bit   m_lvl = 0, m_pol = 0, m_pace = 0, m_err = 0;
  bit   hist[$] = '{0, 0, 0};

  function automatic bit m_hit();
    if (m_lvl) return hist[1] ^ m_pol;
    if (m_pol) return !hist[1] && hist[2];
    return hist[1] && !hist[2];
  endfunction

  function automatic bit m_ack();  return m_st == 2; endfunction
  function automatic bit m_beat(); return m_ack() && bus_ta && !bus_tea; endfunction
  function automatic bit m_done(); return m_beat() && m_rem == 1; endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_lvl = 0; m_pol = 0; m_pace = 0; m_err = 0;
      hist = '{0, 0, 0};
    end else begin
      case (m_st)
        0: if (cfg_arm && cfg_count != 0) begin
             m_lvl = cfg_level_mode; m_pol = cfg_invert; m_pace = cfg_pace;
             m_rem = cfg_count; m_err = 0; m_st = 1;
           end
        1: if (m_hit()) m_st = 2;
        default: begin
          if (bus_tea) begin m_err = 1; m_st = 0; end
          else if (bus_ta) begin
            if (m_rem == 1) m_st = 0;
            else begin m_rem--; if (m_pace) m_st = 1; end
          end
        end
      endcase
      hist.push_front(req_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] %s actual=%0b expected=%0b t=%0t", req, scen, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R6", "ack_out", ack_out, m_ack());
    chk("R7", "beat_ok", beat_ok, m_beat());
    chk("R8", "done_out", done_out, m_done());
    chk("R4", "armed", armed, m_st != 0);
    chk("R9", "err_flag", err_flag, m_err);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      #1 compare_all();
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic arm(bit lvl, bit pol, bit pace, int cnt);
    cfg_level_mode = lvl; cfg_invert = pol; cfg_pace = pace; cfg_count = CNT_W'(cnt);
    cfg_arm = 1'b1;
    tick(1);
    cfg_arm = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cycles == WD_LIMIT) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R4", "reset armed", armed, 1'b0);
    chk("R6", "reset ack", ack_out, 1'b0);
    chk("R8", "reset done", done_out, 1'b0);
    chk("R9", "reset err", err_flag, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(5);

    // R5: requests while unarmed, then a pre-arm edge that must be lost
    scen = "R5 unarmed";
    req_in = 1; tick(6); req_in = 0; tick(4); req_in = 1; tick(4);
    chk("R5", "no access unarmed", ack_out, 1'b0);
    arm(0, 0, 0, 1);
    tick(6);
    chk("R5", "pre-arm edge lost", ack_out, 1'b0);
    // R11: terminations while waiting are ignored
    scen = "R11 idle termination";
    bus_ta = 1; bus_tea = 1; tick(3); bus_ta = 0; bus_tea = 0;
    chk("R11", "still armed", armed, 1'b1);
    chk("R11", "no error", err_flag, 1'b0);
    req_in = 0; tick(3); req_in = 1; tick(4);
    chk("R3", "rising edge starts", ack_out, 1'b1);
    bus_ta = 1; #1;
    chk("R8", "done with single beat", done_out, 1'b1);
    tick(1); bus_ta = 0; tick(2);

    // R1 / R2: level high, three beats back to back
    scen = "R1 R2 level high";
    req_in = 0; tick(3);
    arm(1, 0, 0, 3);
    req_in = 1;
    tick(2);
    chk("R1", "no ack after two edges", ack_out, 1'b0);
    tick(1);
    chk("R1", "ack after third edge", ack_out, 1'b1);
    bus_ta = 1; tick(3); bus_ta = 0;
    chk("R8", "idle after done", armed, 1'b0);
    req_in = 0; tick(3);

    // R2 active low with held access (R6)
    scen = "R2 level low";
    req_in = 1; tick(3);
    arm(1, 1, 0, 2);
    tick(4);
    chk("R2", "high line not a request", ack_out, 1'b0);
    req_in = 0; tick(3);
    chk("R2", "low line requests", ack_out, 1'b1);
    tick(3);
    chk("R6", "ack held without termination", ack_out, 1'b1);
    bus_ta = 1; tick(2); bus_ta = 0; req_in = 1; tick(3);

    // R3 / R10: falling edge with pacing
    scen = "R3 R10 falling paced";
    arm(0, 1, 1, 3);
    for (int b = 0; b < 3; b++) begin
      req_in = 0; tick(3);
      chk("R3", "falling edge starts beat", ack_out, 1'b1);
      bus_ta = 1; tick(1); bus_ta = 0;
      tick(4);
      chk("R10", "paced beat waits", ack_out, 1'b0);
      req_in = 1; tick(3);
    end
    chk("R8", "paced transfer complete", armed, 1'b0);

    // R10 level mode paced with request held, ta always high
    scen = "R10 level paced";
    req_in = 0; arm(1, 0, 1, 3);
    req_in = 1; bus_ta = 1; tick(12); bus_ta = 0; req_in = 0; tick(3);
    chk("R10", "paced level done", armed, 1'b0);

    // R3 rising edge, no pacing, four beats with gaps in ta
    scen = "R3 rising unpaced";
    arm(0, 0, 0, 4);
    req_in = 1; tick(3);
    bus_ta = 1; tick(2); bus_ta = 0; tick(2);
    chk("R10", "unpaced keeps ack", ack_out, 1'b1);
    bus_ta = 1; tick(2); bus_ta = 0; tick(2);
    req_in = 0; tick(2);

    // R9 / R7: error abort with both terminations at once
    scen = "R9 abort";
    arm(1, 0, 0, 5);
    req_in = 1; tick(3);
    bus_ta = 1; tick(2);
    bus_tea = 1; #1;
    chk("R7", "tea blocks beat", beat_ok, 1'b0);
    chk("R9", "no done on error", done_out, 1'b0);
    tick(1); bus_ta = 0; bus_tea = 0;
    chk("R9", "aborted", armed, 1'b0);
    chk("R9", "error set", err_flag, 1'b1);
    tick(5);
    chk("R9", "error sticky", err_flag, 1'b1);

    // R4: zero count ignored, arm while busy ignored
    scen = "R4 arm rules";
    arm(1, 0, 0, 0);
    tick(2);
    chk("R4", "zero count ignored", armed, 1'b0);
    chk("R4", "zero count keeps error", err_flag, 1'b1);
    arm(1, 0, 0, 2);
    chk("R4", "arm clears error", err_flag, 1'b0);
    tick(3);
    arm(0, 1, 1, 7);
    tick(2);
    bus_ta = 1; tick(2); bus_ta = 0;
    chk("R4", "busy arm ignored, count kept", armed, 1'b0);
    req_in = 0; tick(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule